// File: doc/BRIEF.md
# Start-up Supply Source Sequencer

This block sequences an on-chip high-voltage start-up current source so that it first charges the controller supply rail and then holds it. The comparator outputs on the rail arrive as digital flags, one for each of five levels: inhibit, minimum, turn-on, turn-off and logic reset. Two more flags report that the high-voltage pin is above its minimum operating level and that thermal shutdown is active. The block selects the source current: off, a low short-protection current while the rail is still near ground, or the full start-up current. It switches the source off at the turn-on level and back on at the minimum level. The result is a hysteretic self-supply that keeps the rail between those two levels.

The block also issues a one-cycle controller-start pulse when the rail reaches the turn-on level while the controller is stopped. It stops the controller and pulses a fault-timer clear when the rail drops below the turn-off level. While the rail is below the logic-reset level it holds the fault-timer clear high. As a result, a short off/on cycle of the application restarts cleanly without an extra delay. All flags pass through a two-stage synchroniser, and every output is registered.

Top module: `supply_src_seq`

## Requirements
- R1: While rst_ni is low, src_sel_o is 2'b00 (off) and ctrl_start_o and fault_clr_o are 0.
- R2: The source select is 2'b00 (off) whenever hv_ok_i is 0 or tsd_i is 1. No other condition inhibits the source.
- R3: When the source is enabled, src_sel_o is 2'b01 (low current) while vcc_inh_i is 0, and 2'b10 (high current) while vcc_inh_i is 1.
- R4: The source turns off once vcc_on_i is 1. It stays off until vcc_min_i is 0, and then it turns on again. At reset the block starts in the charging state.
- R5: ctrl_start_o pulses for exactly one cycle when vcc_on_i is 1 and the controller is stopped. The controller is stopped after reset and after a stop event. There is no further pulse while the controller runs.
- R6: When vcc_off_i is 0 while the controller runs, the controller stops and fault_clr_o pulses for one cycle. The next time vcc_on_i is 1, ctrl_start_o pulses again.
- R7: fault_clr_o is 1 in every cycle that follows a cycle in which vcc_rst_i was 0 (subject to the R8 latency).
- R8: An input change reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages plus one output register.
- R9: src_sel_o never takes the value 2'b11, so low and high current are never selected together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_inh_i | input | 1 | Rail above inhibit level |
| vcc_min_i | input | 1 | Rail above minimum (restart) level |
| vcc_on_i | input | 1 | Rail above turn-on level |
| vcc_off_i | input | 1 | Rail above turn-off level |
| vcc_rst_i | input | 1 | Rail above logic-reset level |
| hv_ok_i | input | 1 | High-voltage pin above minimum operating level |
| tsd_i | input | 1 | Thermal shutdown active |
| src_sel_o | output | 2 | Source select: 00 off, 01 low, 10 high |
| ctrl_start_o | output | 1 | One-cycle controller start pulse |
| fault_clr_o | output | 1 | Fault-timer clear |

## Verification
The assertions assume that the rail flags form a consistent thermometer code: a flag for a higher level is set only when every flag for a lower level is also set. They also assume that each flag is stable long enough to be seen across the three-cycle latency. The bench meets both assumptions by deriving every rail flag from a single modelled rail voltage, with thresholds at 1.0, 5.0, 9.5, 10.5 and 12.0 V. That voltage charges according to the source current the block selects and drains by a random load. Random unplug events and thermal-shutdown pulses drive the rail down through the turn-off and reset levels.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_LOW  = 2'b01,
    SRC_HIGH = 2'b10
  } src_sel_e;

  localparam int unsigned NUM_FLAGS = 7;
  localparam int unsigned F_INH = 0;
  localparam int unsigned F_MIN = 1;
  localparam int unsigned F_ON  = 2;
  localparam int unsigned F_OFF = 3;
  localparam int unsigned F_RST = 4;
  localparam int unsigned F_HV  = 5;
  localparam int unsigned F_TSD = 6;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/src_ctrl.sv
module src_ctrl
  import supply_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     inh_i,
  input  logic     min_i,
  input  logic     on_i,
  input  logic     hv_ok_i,
  input  logic     tsd_i,
  output src_sel_e sel_o
);
  logic     charge_q, charge_d;
  logic     allow;
  src_sel_e sel_d, sel_q;

  // hysteresis: stop at turn-on level, resume below minimum
  always_comb begin
    charge_d = charge_q;
    if (on_i)        charge_d = 1'b0;
    else if (!min_i) charge_d = 1'b1;
  end

  assign allow = hv_ok_i && !tsd_i && charge_d;

  always_comb begin
    if (!allow)     sel_d = SRC_OFF;
    else if (!inh_i) sel_d = SRC_LOW;
    else            sel_d = SRC_HIGH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      charge_q <= 1'b1;
      sel_q    <= SRC_OFF;
    end else begin
      charge_q <= charge_d;
      sel_q    <= sel_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  input  logic rst_lvl_i,
  output logic start_o,
  output logic clr_o
);
  logic run_q, start_q, clr_q;
  logic do_start, do_stop;

  assign do_start = !run_q && on_i;
  assign do_stop  = run_q && !off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      if (do_start)     run_q <= 1'b1;
      else if (do_stop) run_q <= 1'b0;
      start_q <= do_start;
      clr_q   <= do_stop || !rst_lvl_i;
    end
  end

  assign start_o = start_q;
  assign clr_o   = clr_q;
endmodule

// File: rtl/supply_src_seq.sv
module supply_src_seq
  import supply_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_inh_i,
  input  logic       vcc_min_i,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       vcc_rst_i,
  input  logic       hv_ok_i,
  input  logic       tsd_i,
  output logic [1:0] src_sel_o,
  output logic       ctrl_start_o,
  output logic       fault_clr_o
);
  logic [NUM_FLAGS-1:0] raw, syn;
  src_sel_e             sel;

  always_comb begin
    raw        = '0;
    raw[F_INH] = vcc_inh_i;
    raw[F_MIN] = vcc_min_i;
    raw[F_ON]  = vcc_on_i;
    raw[F_OFF] = vcc_off_i;
    raw[F_RST] = vcc_rst_i;
    raw[F_HV]  = hv_ok_i;
    raw[F_TSD] = tsd_i;
  end

  flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  src_ctrl u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inh_i  (syn[F_INH]),
    .min_i  (syn[F_MIN]),
    .on_i   (syn[F_ON]),
    .hv_ok_i(syn[F_HV]),
    .tsd_i  (syn[F_TSD]),
    .sel_o  (sel)
  );

  run_ctrl u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .on_i     (syn[F_ON]),
    .off_i    (syn[F_OFF]),
    .rst_lvl_i(syn[F_RST]),
    .start_o  (ctrl_start_o),
    .clr_o    (fault_clr_o)
  );

  assign src_sel_o = sel;
endmodule

// File: rtl/supply_src_seq_chk.sv
module supply_src_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vcc_inh_i,
  input logic       vcc_on_i,
  input logic       vcc_rst_i,
  input logic       hv_ok_i,
  input logic       tsd_i,
  input logic [1:0] src_sel_o,
  input logic       ctrl_start_o,
  input logic       fault_clr_o
);
  logic [1:0] cyc_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end
  assign warm = (cyc_q == 2'd3);

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o != 2'b11); // R9
  AST_INHIBIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && ($past(!hv_ok_i, 3) || $past(tsd_i, 3))) |-> src_sel_o == 2'b00); // R2
  AST_ON_LEVEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(vcc_on_i, 3)) |-> src_sel_o == 2'b00); // R4
  AST_LOW_BELOW_INH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && src_sel_o == 2'b01) |-> !$past(vcc_inh_i, 3)); // R3
  AST_HIGH_ABOVE_INH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && src_sel_o == 2'b10) |-> $past(vcc_inh_i, 3)); // R3
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_start_o |=> !ctrl_start_o); // R5
  AST_START_NEEDS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && ctrl_start_o) |-> $past(vcc_on_i, 3)); // R5
  AST_RST_LVL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(vcc_rst_i, 3)) |-> fault_clr_o); // R7
endmodule

bind supply_src_seq supply_src_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vcc_inh_i   (vcc_inh_i),
  .vcc_on_i    (vcc_on_i),
  .vcc_rst_i   (vcc_rst_i),
  .hv_ok_i     (hv_ok_i),
  .tsd_i       (tsd_i),
  .src_sel_o   (src_sel_o),
  .ctrl_start_o(ctrl_start_o),
  .fault_clr_o (fault_clr_o)
);

// File: tb/supply_src_seq_tb_top.sv
`timescale 1ns/1ps
module supply_src_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vcc_inh_i = 1'b0, vcc_min_i = 1'b0, vcc_on_i = 1'b0;
  logic       vcc_off_i = 1'b0, vcc_rst_i = 1'b0;
  logic       hv_ok_i = 1'b0, tsd_i = 1'b0;
  logic [1:0] src_sel_o;
  logic       ctrl_start_o, fault_clr_o;

  int unsigned n_chk = 0, n_bad = 0;
  int          mv = 0;
  bit          done = 1'b0;

  // bench model state
  logic [6:0] m_s1 = '0, m_s2 = '0;
  logic       m_chg = 1'b1, m_run = 1'b0;
  logic [1:0] m_sel = 2'b00;
  logic       m_start = 1'b0, m_clr = 1'b0;
  string      m_sel_tag = "R3";

  always #5 clk_i = ~clk_i;

  supply_src_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .vcc_inh_i(vcc_inh_i), .vcc_min_i(vcc_min_i), .vcc_on_i(vcc_on_i),
    .vcc_off_i(vcc_off_i), .vcc_rst_i(vcc_rst_i),
    .hv_ok_i(hv_ok_i), .tsd_i(tsd_i),
    .src_sel_o(src_sel_o), .ctrl_start_o(ctrl_start_o), .fault_clr_o(fault_clr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // rail flags from modelled voltage (mV); thresholds keep a thermometer order
  task automatic drive_rail();
    vcc_inh_i = (mv >= 1000);
    vcc_rst_i = (mv >= 5000);
    vcc_off_i = (mv >= 9500);
    vcc_min_i = (mv >= 10500);
    vcc_on_i  = (mv >= 12000);
  endtask

  // flag bit order: 0 inh,1 min,2 on,3 off,4 rst,5 hv,6 tsd
  function automatic logic [6:0] cur_flags();
    return {tsd_i, hv_ok_i, vcc_rst_i, vcc_off_i, vcc_on_i, vcc_min_i, vcc_inh_i};
  endfunction

  task automatic model_step();
    logic chg_n, st, sp;
    chg_n = m_s2[2] ? 1'b0 : (!m_s2[1] ? 1'b1 : m_chg);
    if (!m_s2[5] || m_s2[6])      begin m_sel = 2'b00; m_sel_tag = "R2"; end
    else if (!chg_n)              begin m_sel = 2'b00; m_sel_tag = "R4"; end
    else if (!m_s2[0])            begin m_sel = 2'b01; m_sel_tag = "R3"; end
    else                          begin m_sel = 2'b10; m_sel_tag = "R3"; end
    st = !m_run && m_s2[2];
    sp = m_run && !m_s2[3];
    m_start = st;
    m_clr   = sp || !m_s2[4];
    if (st) m_run = 1'b1; else if (sp) m_run = 1'b0;
    m_chg = chg_n;
    m_s2  = m_s1;
    m_s1  = cur_flags();
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    #1;
    chk(src_sel_o == m_sel, m_sel_tag, src_sel_o, m_sel);
    chk(src_sel_o != 2'b11, "R9", src_sel_o, 0);
    chk(ctrl_start_o == m_start, "R5", ctrl_start_o, m_start);
    chk(fault_clr_o == m_clr, m_clr && !m_s1[4] ? "R7" : "R6", fault_clr_o, m_clr);
  endtask

  task automatic rail_update(input int drain_max);
    if (src_sel_o == 2'b10)      mv += 220;
    else if (src_sel_o == 2'b01) mv += 150;
    mv -= int'($urandom_range(0, drain_max));
    if (mv < 0) mv = 0;
    if (mv > 14000) mv = 14000;
    drive_rail();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    int stuck;
    seed_dummy = $urandom(32'd4242);
    drive_rail();
    #23;
    // R1: outputs during reset
    chk(src_sel_o == 2'b00, "R1", src_sel_o, 0);
    chk(ctrl_start_o == 1'b0, "R1", ctrl_start_o, 0);
    chk(fault_clr_o == 1'b0, "R1", fault_clr_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    hv_ok_i = 1'b1;
    // R8: enable must take exactly three edges
    tick(); chk(src_sel_o == 2'b00, "R8", src_sel_o, 0);
    tick(); chk(src_sel_o == 2'b00, "R8", src_sel_o, 0);
    tick(); chk(src_sel_o == 2'b01, "R8", src_sel_o, 1);
    // charge through to first start
    stuck = 0;
    while (!ctrl_start_o && stuck < 2000) begin
      rail_update(40);
      tick();
      stuck++;
    end
    chk(ctrl_start_o == 1'b1, "R5", ctrl_start_o, 1);
    // R8 / R2: thermal shutdown in hysteresis window with source on
    while (src_sel_o == 2'b00) begin rail_update(120); tick(); end
    tsd_i = 1'b1;
    tick(); chk(src_sel_o != 2'b00, "R8", src_sel_o, 2);
    tick(); chk(src_sel_o != 2'b00, "R8", src_sel_o, 2);
    tick(); chk(src_sel_o == 2'b00, "R2", src_sel_o, 0);
    tsd_i = 1'b0;
    // random closed-loop operation with unplug and shutdown events
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 2999) == 0) begin
        hv_ok_i = 1'b0;
        for (int k = 0; k < 600; k++) begin
          rail_update(120);
          tick();
          if (mv < 4000 && k > 200) chk(fault_clr_o == 1'b1, "R7", fault_clr_o, 1);
        end
        hv_ok_i = 1'b1;
      end
      if ($urandom_range(0, 499) == 0) tsd_i = ~tsd_i;
      rail_update(120);
      tick();
    end
    // R6: final unplug, expect a single clear pulse then restart
    tsd_i = 1'b0;
    hv_ok_i = 1'b0;
    stuck = 0;
    while (!fault_clr_o && stuck < 5000) begin rail_update(120); tick(); stuck++; end
    chk(fault_clr_o == 1'b1, "R6", fault_clr_o, 1);
    hv_ok_i = 1'b1;
    stuck = 0;
    while (!ctrl_start_o && stuck < 5000) begin rail_update(40); tick(); stuck++; end
    chk(ctrl_start_o == 1'b1, "R6", ctrl_start_o, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule